// File: doc/BRIEF.md
# Two-Level Priority Interrupt Entry Sequencer

This block sequences interrupt entry and return for a small processor core with two interrupt priority levels. Each cycle it compares the pending high and low requests against two internal enable bits. When a level is taken, it pushes the current program counter onto a hardware return stack and saves the working, status and bank registers into shadow copies. It then clears the enables for the level being entered and asks the core to load the vector for that level. The high level wins a tie and can preempt a low-level handler. The low level never masks the high one.

A return request pops the saved address and re-enables the level that entry had disabled. It can also ask the core to restore the shadow copies. The core writes the enable bits through a simple write strobe. Out of reset the block loads the reset vector.

Top module: `irq_entry_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `pc_load` is 1, `pc_next` is 0x0000, both enables are 0 and `stk_ovf` is 0.
- R2: If `irq_hi` and `en_hi` are both 1 and `retfie` is 0 at a clock edge, then after that edge `pc_load` is 1, `pc_next` is 0x0008, and both `en_hi` and `en_lo` are 0.
- R3: If `irq_lo` and `en_lo` are both 1, no high-level entry is taken and `retfie` is 0 at a clock edge, then after that edge `pc_load` is 1, `pc_next` is 0x0018, `en_lo` is 0 and `en_hi` keeps its value.
- R4: When both levels are pending and enabled at the same edge, only the high level is taken (vector 0x0008).
- R5: Every entry pushes `pc_cur` onto a return stack. Each `retfie` pops it in last-in, first-out order: `pc_load` is 1 and `pc_next` is the popped address.
- R6: Every entry overwrites the shadow outputs `w_sh`, `status_sh` and `bank_sh` with `w_in`, `status_in` and `bank_in`, including a high entry that preempts a low handler. `restore` pulses for one cycle after a `retfie` with `ret_fast` at 1, and stays 0 otherwise.
- R7: On `retfie`, `en_hi` is set if it was 0; otherwise `en_lo` is set.
- R8: A `retfie` takes precedence over any request at the same edge. No entry happens in that cycle.
- R9: The stack holds 31 addresses. An entry with the stack full still vectors but discards the push and sets `stk_ovf`, which then stays at 1 until reset.
- R10: A `retfie` with an empty stack gives `pc_next` = 0x0000 and leaves the stack empty.
- R11: With no entry and no return at an edge, `en_wr` at 1 loads `{en_hi, en_lo}` from `en_wdata` (bit 1 high, bit 0 low). Otherwise all pulse outputs are 0 and the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_hi | input | 1 | High-level request pending |
| irq_lo | input | 1 | Low-level request pending |
| en_wr | input | 1 | Write strobe for the enable bits |
| en_wdata | input | 2 | New enables, bit 1 high level, bit 0 low level |
| retfie | input | 1 | Return from interrupt |
| ret_fast | input | 1 | With `retfie`, request shadow restore |
| pc_cur | input | PC_W | Address to be saved on entry |
| w_in | input | DW | Working register |
| status_in | input | DW | Status register |
| bank_in | input | DW | Bank select register |
| pc_load | output | 1 | Core must load `pc_next` |
| pc_next | output | PC_W | Vector or return address |
| en_hi | output | 1 | High-level enable |
| en_lo | output | 1 | Low-level enable |
| restore | output | 1 | Core must restore from the shadows |
| w_sh | output | DW | Working register shadow |
| status_sh | output | DW | Status register shadow |
| bank_sh | output | DW | Bank select shadow |
| stk_ovf | output | 1 | Sticky return stack overflow |

## Verification
Directed sequences cover the reset state, a same-cycle tie between the levels, and low-then-high preemption. The preemption case must show the shadows overwritten and the return addresses come back in reverse order. Further directed cases cover a return racing a pending request, which separates return precedence from entry precedence, and a return from an empty stack. Thirty-two back-to-back high entries fill the stack so that the overflow flag and the discarded push can be seen, and a full drain checks LIFO order. A long seeded random phase then mixes requests, enable writes and returns. It checks the enable masking rules for each level against a bench model across many interleavings.

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int PC_W      = 16,
  parameter int DW        = 8,
  parameter int STK_DEPTH = 31,
  parameter int RST_VEC   = 'h0000,
  parameter int HI_VEC    = 'h0008,
  parameter int LO_VEC    = 'h0018
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            irq_hi,
  input  logic            irq_lo,
  input  logic            en_wr,
  input  logic [1:0]      en_wdata,
  input  logic            retfie,
  input  logic            ret_fast,
  input  logic [PC_W-1:0] pc_cur,
  input  logic [DW-1:0]   w_in,
  input  logic [DW-1:0]   status_in,
  input  logic [DW-1:0]   bank_in,
  output logic            pc_load,
  output logic [PC_W-1:0] pc_next,
  output logic            en_hi,
  output logic            en_lo,
  output logic            restore,
  output logic [DW-1:0]   w_sh,
  output logic [DW-1:0]   status_sh,
  output logic [DW-1:0]   bank_sh,
  output logic            stk_ovf
);
  localparam int PTR_W = $clog2(STK_DEPTH + 1);

  logic [PC_W-1:0]  stk [STK_DEPTH];
  logic [PTR_W-1:0] ptr;

  wire take_hi = irq_hi & en_hi & ~retfie;
  wire take_lo = irq_lo & en_lo & ~retfie & ~take_hi;
  wire take    = take_hi | take_lo;
  wire full    = (ptr == PTR_W'(STK_DEPTH));
  wire empty   = (ptr == '0);
  wire [PC_W-1:0] tos = empty ? PC_W'(RST_VEC) : stk[ptr - 1'b1];

  always_ff @(posedge clk) begin
    if (take && !full) stk[ptr] <= pc_cur;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      en_hi     <= 1'b0;
      en_lo     <= 1'b0;
      pc_load   <= 1'b1;
      pc_next   <= PC_W'(RST_VEC);
      restore   <= 1'b0;
      w_sh      <= '0;
      status_sh <= '0;
      bank_sh   <= '0;
      stk_ovf   <= 1'b0;
    end else begin
      pc_load <= 1'b0;
      restore <= 1'b0;
      if (retfie) begin
        pc_load <= 1'b1;
        pc_next <= tos;
        restore <= ret_fast;
        if (!empty) ptr <= ptr - 1'b1;
        if (!en_hi) en_hi <= 1'b1;
        else        en_lo <= 1'b1;
      end else if (take) begin
        pc_load   <= 1'b1;
        pc_next   <= take_hi ? PC_W'(HI_VEC) : PC_W'(LO_VEC);
        en_lo     <= 1'b0;
        if (take_hi) en_hi <= 1'b0;
        w_sh      <= w_in;
        status_sh <= status_in;
        bank_sh   <= bank_in;
        if (full) stk_ovf <= 1'b1;
        else      ptr     <= ptr + 1'b1;
      end else if (en_wr) begin
        en_hi <= en_wdata[1];
        en_lo <= en_wdata[0];
      end
    end
  end

  AST_HI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_hi && en_hi && !retfie) |=> (pc_load && pc_next == PC_W'(HI_VEC) && !en_hi && !en_lo)); // R2
  AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lo && en_lo && !(irq_hi && en_hi) && !retfie) |=> (pc_next == PC_W'(LO_VEC) && !en_lo && en_hi == $past(en_hi))); // R3
  AST_RET_REENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (retfie && !en_hi) |=> (en_hi && pc_load)); // R7
  AST_RESTORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    restore |-> $past(retfie && ret_fast)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf); // R9
endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
  logic clk = 0, rst_n = 0;
  logic irq_hi = 0, irq_lo = 0, en_wr = 0, retfie = 0, ret_fast = 0;
  logic [1:0] en_wdata = 0;
  logic [15:0] pc_cur = 0;
  logic [7:0] w_in = 0, status_in = 0, bank_in = 0;
  logic pc_load, en_hi, en_lo, restore, stk_ovf;
  logic [15:0] pc_next;
  logic [7:0] w_sh, status_sh, bank_sh;

  irq_entry_seq u0 (.clk, .rst_n, .irq_hi, .irq_lo, .en_wr, .en_wdata, .retfie, .ret_fast,
    .pc_cur, .w_in, .status_in, .bank_in, .pc_load, .pc_next, .en_hi, .en_lo, .restore,
    .w_sh, .status_sh, .bank_sh, .stk_ovf);

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit m_hi, m_lo, m_ovf, e_load, e_rst;
  logic [15:0] mstk [32];
  int mcnt;
  logic [15:0] e_pc;
  logic [7:0] mw, ms, mb;
  string etag;

  task automatic chk(string tag, int act, int exp, string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_hi = 0; m_lo = 0; m_ovf = 0; mcnt = 0; mw = 0; ms = 0; mb = 0;
  endtask

  task automatic step(bit h, bit l, bit ew, logic [1:0] ewd, bit rt, bit rf,
                      logic [15:0] pc, logic [7:0] w, logic [7:0] s, logic [7:0] b);
    e_load = 0; e_rst = 0; etag = "R11";
    if (rt) begin
      e_load = 1; e_rst = rf;
      e_pc = (mcnt > 0) ? mstk[mcnt-1] : 16'h0000;
      etag = (mcnt > 0) ? "R5" : "R10";
      if (mcnt > 0) mcnt--;
      if (!m_hi) m_hi = 1; else m_lo = 1;
    end else if ((h && m_hi) || (l && m_lo)) begin
      e_load = 1;
      if (h && m_hi) begin e_pc = 16'h0008; m_hi = 0; etag = "R2"; end
      else begin e_pc = 16'h0018; etag = "R3"; end
      m_lo = 0; mw = w; ms = s; mb = b;
      if (mcnt == 31) begin m_ovf = 1; etag = "R9"; end
      else begin mstk[mcnt] = pc; mcnt++; end
    end else if (ew) begin
      m_hi = ewd[1]; m_lo = ewd[0];
    end
  endtask

  task automatic cyc(bit h, bit l, bit ew, logic [1:0] ewd, bit rt, bit rf,
                     logic [15:0] pc, logic [7:0] w, logic [7:0] s, logic [7:0] b, string force_tag);
    irq_hi = h; irq_lo = l; en_wr = ew; en_wdata = ewd; retfie = rt; ret_fast = rf;
    pc_cur = pc; w_in = w; status_in = s; bank_in = b;
    step(h, l, ew, ewd, rt, rf, pc, w, s, b);
    if (force_tag != "") etag = force_tag;
    @(negedge clk);
    chk(etag, pc_load, e_load, "pc_load");
    if (e_load) chk(etag, pc_next, e_pc, "pc_next");
    chk(etag == "R3" ? "R3" : "R7", en_hi, m_hi, "en_hi");
    chk(etag, en_lo, m_lo, "en_lo");
    chk("R9", stk_ovf, m_ovf, "stk_ovf");
    chk("R6", restore, e_rst, "restore");
    chk("R6", {w_sh, status_sh, bank_sh}, {mw, ms, mb}, "shadows");
  endtask

  bit done = 0;
  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1", pc_load, 1, "pc_load");
    chk("R1", pc_next, 16'h0000, "pc_next");
    chk("R1", {en_hi, en_lo}, 0, "enables");
    chk("R1", stk_ovf, 0, "stk_ovf");
    rst_n = 1;
    cyc(0,0,0,0,0,0,0,0,0,0,"R1");
    cyc(0,0,1,2'b11,0,0,0,0,0,0,"R11");
    cyc(1,1,0,0,0,0,16'h1234,8'h11,8'h22,8'h33,"R4");
    cyc(0,0,0,0,1,1,0,0,0,0,"R5");
    cyc(0,0,1,2'b11,0,0,0,0,0,0,"R11");
    cyc(0,1,0,0,0,0,16'h0400,8'hA1,8'hA2,8'hA3,"R3");
    cyc(1,0,0,0,0,0,16'h0022,8'hB1,8'hB2,8'hB3,"R6");
    cyc(0,0,0,0,1,1,0,0,0,0,"R5");
    cyc(1,0,0,0,1,0,0,0,0,0,"R8");
    cyc(0,0,0,0,0,0,0,0,0,0,"R7");
    cyc(0,0,0,0,1,0,0,0,0,0,"R10");
    for (int i = 0; i < 32; i++) begin
      cyc(0,0,1,2'b11,0,0,0,0,0,0,"R11");
      cyc(1,0,0,0,0,0,16'(16'h2000 + i),8'(i),8'(i+1),8'(i+2),"R9");
    end
    for (int i = 0; i < 32; i++) cyc(0,0,0,0,1,0,0,0,0,0,"");
    rst_n = 0;
    @(negedge clk);
    model_reset();
    chk("R1", stk_ovf, 0, "stk_ovf after reset");
    rst_n = 1;
    cyc(0,0,0,0,0,0,0,0,0,0,"R1");
    void'($urandom(32'd2024));
    for (int i = 0; i < 4000; i++) begin
      int unsigned r = $urandom;
      cyc(r[0] & r[1], r[2] & r[3], r[4] & r[5] & r[6], r[8:7],
          (r[11:9] == 3'b000), r[12], 16'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), "");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule